// File: doc/BRIEF.md
# Cartridge Bus Access Decoder

This block sits on the edge connector of a handheld console cartridge. The console drives a 20-bit address, a memory/port select, active-low read and write strobes, a cartridge select and a 16-bit bidirectional data bus, all asynchronous to the cartridge. The block decodes each access combinationally to place read data on the bus in time. It also turns every strobe into a single clean event in a fast local clock domain, carrying the target class, the port number and any write data.

Memory accesses are split into an SRAM segment and a ROM area. Accesses to the lowest 64 KiB segment are not answered. Port accesses carry the port number on the low eight address lines and a copy of its upper nibble on the top four lines. A port access is honoured only when that copy agrees, and only for the upper quarter of the port space. Four 8-bit bank registers live at the first cartridge ports. ROM reads are one byte or one word wide, set by a configuration input. SRAM and port reads are always one byte wide.

Top module: `cart_bus_decoder`

## Requirements
- R1: With `mem_sel`=1, address bits 19:16 equal to 0 give class NONE (`acc_kind`=0). Equal to 1 gives SRAM (2). Any other value gives ROM (1).
- R2: With `mem_sel`=0, the port is `addr[7:0]`. A port of 0xC0 or higher whose copy in `addr[19:16]` equals `addr[7:4]` gives class PORT (3), and `acc_port` holds the port number.
- R3: A port access at 0xC0 or higher whose `addr[19:16]` differs from `addr[7:4]` gives class NONE with `acc_bad`=1. Nothing is driven and no register changes. Any other access leaves `acc_bad`=0.
- R4: Each falling edge of `rd_n` while `sel_n` is low gives exactly one single-cycle `rd_pulse`. `wr_n` gives `wr_pulse` in the same way. Each pulse arrives within four clocks of the edge. With `sel_n` high, no pulse is produced.
- R5: On a write event, `acc_data` holds the value on the data bus during the write strobe.
- R6: A write to port 0xC0+k (k = 0..3) loads byte k of `bank_regs` (bits 8k+7:8k) from data bits 7:0. Reset sets every bank byte to 0xFF.
- R7: A ROM read with `rom_wide`=1 drives all 16 data lines with `mem_rdata`. `mem_addr` then equals the address with bit 0 forced to 0.
- R8: SRAM reads and ROM reads with `rom_wide`=0 use `mem_addr` = `addr`. They drive data bits 7:0 with `mem_rdata[15:8]` when `addr[0]`=1 and with `mem_rdata[7:0]` when `addr[0]`=0.
- R9: A read of port 0xC0..0xC3 drives data bits 7:0 with the matching bank byte. A read of any other cartridge port drives 0xFF.
- R10: The data bus is released unless `sel_n` is low, `rd_n` is low and the class is not NONE. The upper byte is driven only for wide ROM reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 20 | Console address lines |
| mem_sel | input | 1 | 1 = memory access, 0 = port access |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| sel_n | input | 1 | Active-low cartridge select |
| rom_wide | input | 1 | 1 = ROM accessed as 16-bit words |
| data_io | inout | 16 | Bidirectional data bus |
| mem_rdata | input | 16 | Word returned by ROM/SRAM storage at mem_addr |
| mem_addr | output | 20 | Address presented to ROM/SRAM storage |
| rd_pulse | output | 1 | One-cycle read event |
| wr_pulse | output | 1 | One-cycle write event |
| acc_kind | output | 2 | Class of last event: 0 none, 1 ROM, 2 SRAM, 3 port |
| acc_port | output | 8 | Port number of last event |
| acc_bad | output | 1 | Last event was a port access with mismatched copy |
| acc_data | output | 16 | Data captured by last write |
| bank_regs | output | 32 | Four bank registers, byte k = port 0xC0+k |

## Verification
The hardest case is a port access whose upper-nibble copy disagrees. It is flagged but has no other effect, and a correct console never produces it. The random stimulus corrupts the copy on about one port access in eight, including writes aimed at the bank ports. The bench then reads the banks back through ordinary port reads to show that they are unchanged. Directed cases cover the boundaries: port 0xBF against 0xC0, memory 0x0FFFF against 0x10000, the SRAM/ROM edge, and odd addresses in both ROM widths.

// File: rtl/cart_bus_decoder.sv
module cart_bus_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int NBANK = 4,
  parameter logic [3:0] SRAM_SEG = 4'h1,
  parameter logic [7:0] BANK_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] addr,
  input  logic        mem_sel,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        sel_n,
  input  logic        rom_wide,
  inout  wire  [15:0] data_io,
  input  logic [15:0] mem_rdata,
  output logic [19:0] mem_addr,
  output logic        rd_pulse,
  output logic        wr_pulse,
  output logic [1:0]  acc_kind,
  output logic [7:0]  acc_port,
  output logic        acc_bad,
  output logic [15:0] acc_data,
  output logic [NBANK*8-1:0] bank_regs
);
  localparam logic [1:0] K_NONE = 2'd0, K_ROM = 2'd1, K_SRAM = 2'd2, K_PORT = 2'd3;
  localparam int BSEL = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [7:0] PORT_LO = 8'hC0;

  logic [1:0] kind;
  logic [7:0] port_off, lo_val, byte_sel, bank_val;
  logic       port_hit, mirror_ok, bad, is_bank, rd_act, lo_en, hi_en;
  logic [7:0] bank [NBANK];

  assign port_hit  = addr[7:6] == 2'b11;
  assign mirror_ok = addr[19:16] == addr[7:4];
  assign port_off  = addr[7:0] - PORT_LO;
  assign bad       = !mem_sel && port_hit && !mirror_ok;

  always_comb begin
    if (mem_sel)
      kind = (addr[19:16] == 4'h0) ? K_NONE : (addr[19:16] == SRAM_SEG) ? K_SRAM : K_ROM;
    else
      kind = (port_hit && mirror_ok) ? K_PORT : K_NONE;
  end

  assign is_bank  = (kind == K_PORT) && (port_off < 8'(NBANK));
  assign bank_val = bank[port_off[BSEL-1:0]];
  assign mem_addr = {addr[19:1], addr[0] & !(kind == K_ROM && rom_wide)};
  assign byte_sel = addr[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  always_comb begin
    case (kind)
      K_ROM:   lo_val = rom_wide ? mem_rdata[7:0] : byte_sel;
      K_SRAM:  lo_val = byte_sel;
      K_PORT:  lo_val = is_bank ? bank_val : 8'hFF;
      default: lo_val = 8'hFF;
    endcase
  end

  assign rd_act = !sel_n && !rd_n && (kind != K_NONE);
  assign lo_en  = rd_act;
  assign hi_en  = rd_act && (kind == K_ROM) && rom_wide;
  assign data_io[7:0]  = lo_en ? lo_val : 8'hzz;
  assign data_io[15:8] = hi_en ? mem_rdata[15:8] : 8'hzz;

  logic [SYNC_STAGES:0] rd_sh, wr_sh;
  logic rd_fall, wr_fall;
  assign rd_fall = rd_sh[SYNC_STAGES] && !rd_sh[SYNC_STAGES-1];
  assign wr_fall = wr_sh[SYNC_STAGES] && !wr_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh    <= '1;
      wr_sh    <= '1;
      rd_pulse <= 1'b0;
      wr_pulse <= 1'b0;
      acc_kind <= K_NONE;
      acc_port <= 8'h00;
      acc_bad  <= 1'b0;
      acc_data <= 16'h0000;
    end else begin
      rd_sh    <= {rd_sh[SYNC_STAGES-1:0], rd_n};
      wr_sh    <= {wr_sh[SYNC_STAGES-1:0], wr_n};
      rd_pulse <= rd_fall && !sel_n;
      wr_pulse <= wr_fall && !sel_n;
      if ((rd_fall || wr_fall) && !sel_n) begin
        acc_kind <= kind;
        acc_port <= mem_sel ? 8'h00 : addr[7:0];
        acc_bad  <= bad;
      end
      if (wr_fall && !sel_n) acc_data <= data_io;
    end
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank[k] <= BANK_RST;
      else if (wr_fall && !sel_n && is_bank && port_off[BSEL-1:0] == BSEL'(k))
        bank[k] <= data_io[7:0];
    end
    assign bank_regs[k*8 +: 8] = bank[k];
  end
endmodule

module cart_bus_decoder_chk #(parameter int NBANK = 4) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic rd_n,
  input logic rd_pulse,
  input logic wr_pulse,
  input logic [1:0] acc_kind,
  input logic [7:0] acc_port,
  input logic acc_bad,
  input logic [15:0] acc_data,
  input logic [NBANK*8-1:0] bank_regs,
  input logic lo_en,
  input logic hi_en
);
  a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n) rd_pulse |=> !rd_pulse);
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n) wr_pulse |=> !wr_pulse);
  a_r3_bad_silent: assert property (@(posedge clk) disable iff (!rst_n) acc_bad |-> acc_kind == 2'd0);
  a_r10_bus_idle: assert property (@(posedge clk) disable iff (!rst_n) (sel_n || rd_n) |-> !lo_en && !hi_en);
  a_r10_hi_lane: assert property (@(posedge clk) disable iff (!rst_n) hi_en |-> lo_en);
  a_r6_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && acc_kind == 2'd3 && acc_port >= 8'hC0 && acc_port < 8'(8'hC0 + NBANK))
    |-> bank_regs[(acc_port - 8'hC0) * 8 +: 8] == acc_data[7:0]);
endmodule

bind cart_bus_decoder cart_bus_decoder_chk #(.NBANK(NBANK)) chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .rd_pulse(rd_pulse),
  .wr_pulse(wr_pulse), .acc_kind(acc_kind), .acc_port(acc_port), .acc_bad(acc_bad),
  .acc_data(acc_data), .bank_regs(bank_regs), .lo_en(lo_en), .hi_en(hi_en));

// File: tb/cart_bus_decoder_test.sv
module cart_bus_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [19:0] addr = '0;
  logic mem_sel = 1, rd_n = 1, wr_n = 1, sel_n = 1, rom_wide = 0;
  logic tb_en = 0;
  logic [15:0] tb_val = '0;
  wire  [15:0] bus;
  logic [15:0] mem_rdata;
  logic [19:0] mem_addr;
  logic rd_pulse, wr_pulse, acc_bad;
  logic [1:0] acc_kind;
  logic [7:0] acc_port;
  logic [15:0] acc_data;
  logic [31:0] bank_regs;

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [7:0] mbank [4];

  always #10 clk = ~clk;
  assign bus = tb_en ? tb_val : 16'hzzzz;

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h9A5};
  endfunction
  assign mem_rdata = mem_word(mem_addr);

  cart_bus_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_sel(mem_sel), .rd_n(rd_n), .wr_n(wr_n),
    .sel_n(sel_n), .rom_wide(rom_wide), .data_io(bus), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .acc_kind(acc_kind),
    .acc_port(acc_port), .acc_bad(acc_bad), .acc_data(acc_data), .bank_regs(bank_regs));

  always @(negedge clk) begin
    cyc++;
    if (rd_pulse) rd_cnt++;
    if (wr_pulse) wr_cnt++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_kind(input logic m, input logic [19:0] a);
    if (m) return (a[19:16] == 0) ? 2'd0 : (a[19:16] == 1) ? 2'd2 : 2'd1;
    return (a[7:6] == 2'b11 && a[19:16] == a[7:4]) ? 2'd3 : 2'd0;
  endfunction

  task automatic access(input logic wr, input logic m, input logic [19:0] a,
                        input logic [15:0] wd, input logic sel);
    int r0, w0;
    logic [1:0] k;
    logic bad;
    logic [15:0] w, got;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    addr = a; mem_sel = m; sel_n = sel;
    tb_en = wr; tb_val = wd;
    @(negedge clk);
    if (wr) wr_n = 0; else rd_n = 0;
    repeat (6) @(negedge clk);
    k = exp_kind(m, a);
    bad = !m && a[7:6] == 2'b11 && a[19:16] != a[7:4];
    if (!wr && !sel && k != 0) begin
      got = bus;
      if (k == 1 && rom_wide) begin
        chk("R7 wide rom addr", {12'h0, mem_addr}, {12'h0, a[19:1], 1'b0});
        chk("R7 wide rom data", {16'h0, got}, {16'h0, mem_word({a[19:1], 1'b0})});
      end else if (k == 3) begin
        chk("R9 port read", {24'h0, got[7:0]},
            {24'h0, (a[7:0] < 8'hC4) ? mbank[a[1:0]] : 8'hFF});
      end else begin
        w = mem_word(a);
        chk("R8 byte addr", {12'h0, mem_addr}, {12'h0, a});
        chk("R8 byte data", {24'h0, got[7:0]}, {24'h0, a[0] ? w[15:8] : w[7:0]});
      end
    end
    rd_n = 1; wr_n = 1;
    repeat (3) @(negedge clk);
    tb_en = 0; sel_n = 1;
    if (sel) begin
      chk("R4 no pulse when deselected", rd_cnt + wr_cnt, r0 + w0);
      return;
    end
    chk("R4 one read pulse", rd_cnt - r0, wr ? 0 : 1);
    chk("R4 one write pulse", wr_cnt - w0, wr ? 1 : 0);
    chk(m ? "R1 mem class" : "R2 port class", {30'h0, acc_kind}, {30'h0, k});
    chk("R3 bad flag", {31'h0, acc_bad}, {31'h0, bad});
    if (k == 3) chk("R2 port number", {24'h0, acc_port}, {24'h0, a[7:0]});
    if (wr) begin
      chk("R5 write data", {16'h0, acc_data}, {16'h0, wd});
      if (k == 3 && a[7:0] < 8'hC4) mbank[a[1:0]] = wd[7:0];
    end
    chk("R6 banks", bank_regs, {mbank[3], mbank[2], mbank[1], mbank[0]});
  endtask

  function automatic logic [19:0] port_addr(input logic [7:0] p);
    return {p[7:4], 8'h00, p};
  endfunction

  initial begin
    int unused;
    unused = $urandom(32'd2718);
    for (int i = 0; i < 4; i++) mbank[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset banks", bank_regs, 32'hFFFF_FFFF);
    chk("R4 reset pulses", {30'h0, rd_pulse, wr_pulse}, 32'h0);
    chk("R1 reset class", {30'h0, acc_kind}, 32'h0);

    access(0, 1, 20'h0FFFF, 0, 0);
    access(0, 1, 20'h10000, 0, 0);
    access(0, 1, 20'h1FFFF, 0, 0);
    access(0, 1, 20'h20001, 0, 0);
    rom_wide = 1;
    access(0, 1, 20'h20001, 0, 0);
    access(0, 1, 20'h10003, 0, 0);
    access(1, 0, port_addr(8'hC2), 16'h1234, 0);
    access(0, 0, port_addr(8'hC2), 0, 0);
    access(1, 0, {4'h3, 8'h00, 8'hC1}, 16'h00AB, 0);
    access(0, 0, port_addr(8'hC1), 0, 0);
    access(1, 0, port_addr(8'hBF), 16'h0055, 0);
    access(0, 0, port_addr(8'hC0), 0, 0);
    access(0, 0, port_addr(8'hE7), 0, 0);
    access(1, 0, port_addr(8'hC3), 16'hBEEF, 1);
    access(0, 0, port_addr(8'hC3), 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [19:0] a;
      logic [7:0] p;
      logic m, wr;
      m  = $urandom_range(0, 1);
      wr = ($urandom_range(0, 2) == 0);
      rom_wide = $urandom_range(0, 1);
      if (m) a = 20'($urandom);
      else begin
        p = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hC3)) : 8'($urandom);
        a = port_addr(p);
        if ($urandom_range(0, 7) == 0) a[19:16] = a[19:16] ^ 4'($urandom_range(1, 15));
      end
      access(wr, m, a, 16'($urandom), ($urandom_range(0, 15) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule